// File: doc/BRIEF.md
# Periodic Tick Interrupt Flag Unit

This block sits beside a real-time clock divider and turns four slow square-wave timing taps into interrupt causes. The taps run at 32 Hz, 8 Hz, 2 Hz and 1 Hz. Each tap goes through its own synchroniser and falling-edge detector. A detected edge sets that tap's sticky cause flag, but only when its enable bit is already 1. The enabled flags are ORed into one registered, level-type request for the system interrupt controller.

Software reaches the block through a small synchronous register port. The port carries an address, a write strobe, byte write data and combinational read data. Two locations are decoded: a flag register, where a written 1 clears a cause, and an enable register, which is plain read/write. An interrupt handler reads the flag register to find which rate fired, then writes ones to clear those causes. Clearing the causes drops the request.

Top module: `ctmr_irq_flags`

## Requirements
- R1: After reset, the flag register and the enable register both read 0, and `irq_o` is 0.
- R2: Bit n of `tap_i`, of the flag register and of the enable register all refer to the same rate: bit 3 is 32 Hz, bit 2 is 8 Hz, bit 1 is 2 Hz and bit 0 is 1 Hz. An edge on one tap sets only its own flag.
- R3: A falling edge on tap n sets flag n when enable n is 1. With two synchroniser stages, the flag reads 1 after the third rising clock edge following the clock edge that first samples the tap low, and still reads 0 after the second. A rising edge on a tap sets nothing.
- R4: A falling edge that arrives while its enable bit is 0 leaves the flag at 0. Setting the enable bit afterwards does not raise the flag or the request.
- R5: Writing the flag register (address 0) with bit n = 1 clears flag n. Writing 0 in bit n leaves flag n unchanged.
- R6: If a clear of flag n and a setting edge for flag n take effect on the same clock edge, the flag ends at 1.
- R7: Bits 7..4 of both registers always read 0, and writes to those bits have no effect.
- R8: The enable register is at address 1, is read/write and holds the value written in bits 3..0. Addresses 2 and 3 read 0 and ignore writes.
- R9: `irq_o` is registered. It equals the OR over n of (flag n AND enable n) and changes on the same clock edge as the flags and enables. It stays high while such a pair remains set, and falls on the edge that clears the last one.
- R10: Clearing a flag never changes the enable register. Writing the enable register never changes a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, applied on the clock edge |
| tap_i | input | 4 | Asynchronous timing taps: [3]=32 Hz, [2]=8 Hz, [1]=2 Hz, [0]=1 Hz |
| reg_addr_i | input | 2 | Register address: 0 = flags, 1 = enables |
| reg_wr_i | input | 1 | Write strobe, acts on the rising clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The assertions take for granted that each tap holds every level for at least three clock cycles. Real taps last milliseconds against a nanosecond clock, so no edge is ever swallowed inside the synchroniser. They also take for granted that the write strobe is a clean synchronous signal held stable around the edge. The stimulus drives every tap and port signal only at falling clock edges. It holds each tap level for at least four cycles before it moves on. It places the write-versus-edge collision on a known edge by counting the synchroniser stages.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    // Default geometry of the tick flag unit
    localparam int unsigned CT_NUM_TAPS    = 4;
    localparam int unsigned CT_DATA_W      = 8;
    localparam int unsigned CT_ADDR_W      = 2;
    localparam int unsigned CT_SYNC_STAGES = 2;

    // Register locations (software-visible)
    localparam int unsigned CT_FLAG_ADDR   = 0;
    localparam int unsigned CT_MASK_ADDR   = 1;

    // Register selection decoded from the address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_MASK = 2'd2
    } ct_sel_e;

endpackage

// File: rtl/ctmr_tap_sync.sv
module ctmr_tap_sync #(
    parameter int unsigned NUM_TAPS = 4,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_TAPS-1:0] tap_i,
    output logic [NUM_TAPS-1:0] fall_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][NUM_TAPS-1:0] chain;
        logic [NUM_TAPS-1:0]             prev;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = tap_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            sync_d.chain[s] = sync_q.chain[s-1];
        end
        sync_d.prev     = sync_q.chain[LAST];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // Falling edge: previously high, synchronised value now low
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_edge
        assign fall_o[t] = sync_q.prev[t] & ~sync_q.chain[LAST][t];
    end

endmodule

// File: rtl/ctmr_reg_if.sv
module ctmr_reg_if
    import ctmr_pkg::*;
#(
    parameter int unsigned NUM_TAPS  = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned FLAG_ADDR = 0,
    parameter int unsigned MASK_ADDR = 1
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_TAPS-1:0] flags_i,
    input  logic [NUM_TAPS-1:0] mask_i,
    output logic [NUM_TAPS-1:0] clr_o,
    output logic                mask_wr_o,
    output logic [NUM_TAPS-1:0] mask_wdata_o,
    output logic [DATA_W-1:0]   rdata_o
);

    ct_sel_e sel;

    always_comb begin
        if (addr_i == ADDR_W'(FLAG_ADDR)) begin
            sel = SEL_FLAG;
        end else if (addr_i == ADDR_W'(MASK_ADDR)) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        clr_o        = '0;
        mask_wr_o    = 1'b0;
        mask_wdata_o = wdata_i[NUM_TAPS-1:0];
        if (wr_i && sel == SEL_FLAG) begin
            clr_o = wdata_i[NUM_TAPS-1:0];
        end
        if (wr_i && sel == SEL_MASK) begin
            mask_wr_o = 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_FLAG: rdata_o[NUM_TAPS-1:0] = flags_i;
            SEL_MASK: rdata_o[NUM_TAPS-1:0] = mask_i;
            default:  rdata_o = '0;
        endcase
    end

    // Upper write-data bits belong to reserved positions and are dropped
    if (DATA_W > NUM_TAPS) begin : g_rsvd
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_TAPS];
    end

endmodule

// File: rtl/ctmr_flag_bank.sv
module ctmr_flag_bank #(
    parameter int unsigned NUM_TAPS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_TAPS-1:0] fall_i,
    input  logic [NUM_TAPS-1:0] clr_i,
    input  logic                mask_wr_i,
    input  logic [NUM_TAPS-1:0] mask_wdata_i,
    output logic [NUM_TAPS-1:0] flags_o,
    output logic [NUM_TAPS-1:0] mask_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [NUM_TAPS-1:0] flags;
        logic [NUM_TAPS-1:0] mask;
        logic                irq;
    } bank_state_t;

    bank_state_t bank_d, bank_q;
    logic [NUM_TAPS-1:0] set_vec;

    // An edge counts only against the enable already in place
    assign set_vec = fall_i & bank_q.mask;

    always_comb begin
        bank_d = bank_q;
        // Set has priority over a same-cycle clear
        bank_d.flags = (bank_q.flags & ~clr_i) | set_vec;
        if (mask_wr_i) begin
            bank_d.mask = mask_wdata_i;
        end
        bank_d.irq = |(bank_d.flags & bank_d.mask);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign flags_o = bank_q.flags;
    assign mask_o  = bank_q.mask;
    assign irq_o   = bank_q.irq;

endmodule

// File: rtl/ctmr_irq_flags.sv
module ctmr_irq_flags
    import ctmr_pkg::*;
#(
    parameter int unsigned NUM_TAPS    = CT_NUM_TAPS,
    parameter int unsigned DATA_W      = CT_DATA_W,
    parameter int unsigned ADDR_W      = CT_ADDR_W,
    parameter int unsigned SYNC_STAGES = CT_SYNC_STAGES,
    parameter int unsigned FLAG_ADDR   = CT_FLAG_ADDR,
    parameter int unsigned MASK_ADDR   = CT_MASK_ADDR
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);

    logic [NUM_TAPS-1:0] tap_fall;
    logic [NUM_TAPS-1:0] clr_bits;
    logic                mask_wr;
    logic [NUM_TAPS-1:0] mask_wdata;
    logic [NUM_TAPS-1:0] flags_q;
    logic [NUM_TAPS-1:0] mask_q;

    ctmr_tap_sync #(
        .NUM_TAPS (NUM_TAPS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tap_i  (tap_i),
        .fall_o (tap_fall)
    );

    ctmr_reg_if #(
        .NUM_TAPS  (NUM_TAPS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_regs (
        .addr_i       (reg_addr_i),
        .wr_i         (reg_wr_i),
        .wdata_i      (reg_wdata_i),
        .flags_i      (flags_q),
        .mask_i       (mask_q),
        .clr_o        (clr_bits),
        .mask_wr_o    (mask_wr),
        .mask_wdata_o (mask_wdata),
        .rdata_o      (reg_rdata_o)
    );

    ctmr_flag_bank #(
        .NUM_TAPS (NUM_TAPS)
    ) u_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fall_i       (tap_fall),
        .clr_i        (clr_bits),
        .mask_wr_i    (mask_wr),
        .mask_wdata_i (mask_wdata),
        .flags_o      (flags_q),
        .mask_o       (mask_q),
        .irq_o        (irq_o)
    );

endmodule

// File: rtl/ctmr_irq_flags_chk.sv
module ctmr_irq_flags_chk #(
    parameter int unsigned NUM_TAPS = 4,
    parameter int unsigned DATA_W   = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_TAPS-1:0] fall,
    input logic [NUM_TAPS-1:0] clr,
    input logic                mask_wr,
    input logic [NUM_TAPS-1:0] flags,
    input logic [NUM_TAPS-1:0] mask,
    input logic [DATA_W-1:0]   rdata,
    input logic                irq
);

    // R7
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata[DATA_W-1:NUM_TAPS] == '0);

    // R9
    irq_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq |-> |(flags & mask));

    // R10
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(mask_wr) |-> $stable(mask));

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_bit
        // R3
        set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(flags[t]) |-> $past(fall[t] && mask[t]));

        // R5
        clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(clr[t] && !(fall[t] && mask[t])) |-> !flags[t]);

        // R6
        set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(fall[t] && mask[t]) |-> flags[t]);

        // R10
        flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(flags[t] && !clr[t]) |-> flags[t]);
    end

endmodule

bind ctmr_irq_flags ctmr_irq_flags_chk #(
    .NUM_TAPS (NUM_TAPS),
    .DATA_W   (DATA_W)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall    (tap_fall),
    .clr     (clr_bits),
    .mask_wr (mask_wr),
    .flags   (flags_q),
    .mask    (mask_q),
    .rdata   (reg_rdata_o),
    .irq     (irq_o)
);

// File: tb/ctmr_irq_flags_tb_top.sv
`timescale 1ns/1ps
module ctmr_irq_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tap = 4'hF;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ctmr_irq_flags dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tap_i       (tap),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic tap_fall(input int n);
        @(negedge clk);
        tap[n] = 1'b0;
        wait_cyc(4);
    endtask

    task automatic tap_rise(input int n);
        @(negedge clk);
        tap[n] = 1'b1;
        wait_cyc(4);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_rd(2'd0, d); chk("R1 flags", d, 8'h00);
        reg_rd(2'd1, d); chk("R1 enables", d, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_disabled_edge();
        logic [7:0] d;
        tap_fall(0);
        reg_rd(2'd0, d); chk("R4 edge while disabled", d, 8'h00);
        reg_wr(2'd1, 8'h01);
        wait_cyc(3);
        reg_rd(2'd0, d); chk("R4 no late set", d, 8'h00);
        chk("R4 irq", {7'd0, irq}, 8'h00);
        tap_rise(0);
        reg_rd(2'd0, d); chk("R3 rising edge no set", d, 8'h00);
        reg_wr(2'd1, 8'h00);
    endtask

    task automatic t_each_tap();
        logic [7:0] d;
        for (int i = 0; i < 4; i++) begin
            reg_wr(2'd1, 8'(1 << i));
            tap_fall(i);
            reg_rd(2'd0, d); chk("R2 R3 own flag only", d, 8'(1 << i));
            chk("R9 irq raised", {7'd0, irq}, 8'h01);
            reg_wr(2'd0, 8'(1 << i));
            reg_rd(2'd0, d); chk("R5 clear", d, 8'h00);
            chk("R9 irq dropped", {7'd0, irq}, 8'h00);
            tap_rise(i);
        end
        reg_wr(2'd1, 8'h00);
    endtask

    task automatic t_timing();
        logic [7:0] d;
        reg_wr(2'd1, 8'h08);
        @(negedge clk);
        tap[3] = 1'b0;
        wait_cyc(2);
        reg_rd(2'd0, d); chk("R3 not yet after two edges", d, 8'h00);
        chk("R9 irq not yet", {7'd0, irq}, 8'h00);
        wait_cyc(1);
        reg_rd(2'd0, d); chk("R3 set after third edge", d, 8'h08);
        chk("R9 irq with flag", {7'd0, irq}, 8'h01);
        wait_cyc(50);
        chk("R9 level holds", {7'd0, irq}, 8'h01);
        reg_wr(2'd0, 8'h08);
        tap_rise(3);
    endtask

    task automatic t_write_zero_rsvd();
        logic [7:0] d;
        reg_wr(2'd1, 8'h04);
        tap_fall(2);
        reg_wr(2'd0, 8'h00);
        reg_rd(2'd0, d); chk("R5 write zero no effect", d, 8'h04);
        reg_wr(2'd0, 8'hF0);
        reg_rd(2'd0, d); chk("R7 reserved write ignored", d, 8'h04);
        tap_rise(2);
    endtask

    task automatic t_mask_indep();
        logic [7:0] d;
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd0, d); chk("R10 enable write keeps flag", d, 8'h04);
        chk("R9 irq follows enable", {7'd0, irq}, 8'h00);
        reg_wr(2'd1, 8'h04);
        chk("R9 irq back with enable", {7'd0, irq}, 8'h01);
        reg_wr(2'd0, 8'h0F);
        reg_rd(2'd1, d); chk("R10 clear keeps enables", d, 8'h04);
        chk("R9 irq after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        reg_wr(2'd1, 8'h02);
        tap_fall(1);
        tap_rise(1);
        reg_rd(2'd0, d); chk("R6 precondition", d, 8'h02);
        @(negedge clk);
        tap[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        addr = 2'd0; wdata = 8'h02; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        reg_rd(2'd0, d); chk("R6 set wins over clear", d, 8'h02);
        reg_wr(2'd0, 8'h02);
        reg_rd(2'd0, d); chk("R5 later clear", d, 8'h00);
        tap_rise(1);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        reg_wr(2'd1, 8'hFA);
        reg_rd(2'd1, d); chk("R7 R8 enable reads low nibble", d, 8'h0A);
        reg_wr(2'd2, 8'hFF);
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd1, d); chk("R8 unused addr write ignored", d, 8'h0A);
        reg_rd(2'd0, d); chk("R8 flags untouched", d, 8'h00);
        reg_rd(2'd2, d); chk("R8 addr 2 reads zero", d, 8'h00);
        reg_rd(2'd3, d); chk("R8 addr 3 reads zero", d, 8'h00);
        reg_wr(2'd1, 8'h00);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_disabled_edge();
        t_each_tap();
        t_timing();
        t_write_zero_rsvd();
        t_mask_indep();
        t_set_wins();
        t_regs();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 20000; k++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule